// File: doc/BRIEF.md
# Status Queue Poster with Interrupt Summary

This block posts completion entries into a set of circular status queues held in a shared memory that a host drains. A producer hands over one entry at a time with a valid/ready handshake, naming the target queue and an entry payload. The block writes the entry into the queue's next slot with the entry's top bit set to 1. That bit acts as an ownership flag: the host processes entries until it meets one whose flag is 0, and it clears the flag of every entry it has consumed.

The host keeps its read position privately and reports it back only now and then, by writing a per-queue read-index register. The block uses that shadow value as the only read pointer it knows, so it may judge a queue full when the host has already drained it. An entry aimed at a full queue is dropped and recorded in a sticky per-queue overflow bit. Every posted entry raises a global "entry posted" status bit and, for queues 0 to 15, a bit in a 16-bit summary register that tells the interrupt handler which queues to visit. The status bits are cleared by writing 1, and an enable register selects which global bits drive the interrupt line.

Top module: `stq_poster`

## Requirements
- R1: An accepted entry for a non-full queue q is written exactly once, in the cycle after acceptance (mem_we high for that one cycle), at address q*DEPTH + write index, with data bit EW-1 set to 1 and the payload in bits EW-2:0.
- R2: The write index of a queue advances by one modulo DEPTH after each entry written to it; it is read back in bits 16+IDXW-1:16 of that queue's index register.
- R3: A queue is full when (write index + 1) mod DEPTH equals its shadow read index; an entry for a full queue is accepted but not written, the write index does not move, and bit q of the overflow register and global status bit 1 are set one cycle after acceptance.
- R4: The shadow read index of queue q (bits IDXW-1:0 of register 4+q) changes only when the host writes that register; posting never moves it.
- R5: Global status bit 0 is set by every written entry and becomes visible on the clock edge that ends the entry's memory write cycle, never earlier.
- R6: A written entry for a queue numbered 0 to 15 sets that queue's bit in the summary register (address 2); an entry for a higher queue sets global status bit 0 but no summary bit.
- R7: Global status (address 0), summary (address 2) and overflow (address 3) bits are cleared by writing 1 to them; when a set and a clear meet in the same cycle, the bit stays set.
- R8: irq is high exactly when a global status bit and its enable bit (address 1, bits 1:0, read/write) are both 1.
- R9: post_ready is low only in the cycle of an entry's memory write; after reset post_ready is high, irq low and all registers read 0.
- R10: A request naming a queue number of NQ or above is accepted and discarded with no write, no status change and no index change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| post_valid | input | 1 | Producer offers an entry |
| post_ready | output | 1 | Block can take an entry this cycle |
| post_queue | input | $clog2(NQ) | Target queue number |
| post_info | input | EW-1 | Entry payload |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | $clog2(NQ)+IDXW | Entry address: queue number above slot index |
| mem_wdata | output | EW | Entry word, ownership flag in the top bit |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | $clog2(NQ+4) | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| irq | output | 1 | Interrupt request |

## Verification
The memory write of an accepted entry is due in the cycle after the accepting edge, so the bench samples the memory port at the falling edge that follows acceptance. The posted status, summary bit and advanced write index appear one edge later, while an overflow and its status bit appear right after the accepting edge; the bench reads the registers at the falling edge after the relevant edge, one nanosecond after driving the address since reads are combinational. irq follows the status and enable registers with no delay, so it is compared against the bench model at those same sample points, including a cycle in which a clear and a set collide.

// File: rtl/stq_poster.sv
module stq_poster #(
  parameter int NQ   = 20,
  parameter int IDXW = 3,
  parameter int EW   = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         post_valid,
  output logic                         post_ready,
  input  logic [$clog2(NQ)-1:0]        post_queue,
  input  logic [EW-2:0]                post_info,
  output logic                         mem_we,
  output logic [$clog2(NQ)+IDXW-1:0]   mem_addr,
  output logic [EW-1:0]                mem_wdata,
  input  logic                         reg_we,
  input  logic [$clog2(NQ+4)-1:0]      reg_addr,
  input  logic [31:0]                  reg_wdata,
  output logic [31:0]                  reg_rdata,
  output logic                         irq
);
  localparam int QW  = $clog2(NQ);
  localparam int RAW = $clog2(NQ+4);

  logic [IDXW-1:0] widx [NQ];
  logic [IDXW-1:0] ridx [NQ];
  logic            busy;
  logic [QW-1:0]   cq;
  logic [EW-2:0]   cinfo;
  logic [1:0]      gstat, ien;
  logic [15:0]     summ;
  logic [NQ-1:0]   ovf;

  logic [IDXW-1:0] sel_w, sel_r, bsy_w;
  logic            inrange, full, acc, take, drop;
  logic [1:0]      g_clr;
  logic [15:0]     s_set, s_clr;
  logic [NQ-1:0]   o_set, o_clr;

  always_comb begin
    sel_w = '0;
    sel_r = '0;
    bsy_w = '0;
    for (int i = 0; i < NQ; i++) begin
      if (32'(post_queue) == i) begin
        sel_w = widx[i];
        sel_r = ridx[i];
      end
      if (32'(cq) == i) bsy_w = widx[i];
    end
  end

  assign post_ready = !busy;
  assign acc        = post_valid && post_ready;
  assign inrange    = 32'(post_queue) < NQ;
  assign full       = (sel_w + IDXW'(1)) == sel_r;
  assign take       = acc && inrange && !full;
  assign drop       = acc && inrange && full;

  assign mem_we    = busy;
  assign mem_addr  = {cq, bsy_w};
  assign mem_wdata = {1'b1, cinfo};

  always_comb begin
    g_clr = (reg_we && reg_addr == RAW'(0)) ? reg_wdata[1:0] : 2'b0;
    s_clr = (reg_we && reg_addr == RAW'(2)) ? reg_wdata[15:0] : 16'b0;
    o_clr = (reg_we && reg_addr == RAW'(3)) ? reg_wdata[NQ-1:0] : '0;
    for (int i = 0; i < 16; i++)
      s_set[i] = busy && (32'(cq) == i);
    for (int i = 0; i < NQ; i++)
      o_set[i] = drop && (32'(post_queue) == i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cq    <= '0;
      cinfo <= '0;
      gstat <= '0;
      ien   <= '0;
      summ  <= '0;
      ovf   <= '0;
      for (int i = 0; i < NQ; i++) begin
        widx[i] <= '0;
        ridx[i] <= '0;
      end
    end else begin
      if (take) begin
        cq    <= post_queue;
        cinfo <= post_info;
      end
      busy  <= take;
      gstat <= (gstat & ~g_clr) | {drop, busy};
      summ  <= (summ & ~s_clr) | s_set;
      ovf   <= (ovf & ~o_clr) | o_set;
      if (reg_we && reg_addr == RAW'(1)) ien <= reg_wdata[1:0];
      for (int i = 0; i < NQ; i++) begin
        if (busy && 32'(cq) == i) widx[i] <= widx[i] + IDXW'(1);
        if (reg_we && 32'(reg_addr) == i + 4) ridx[i] <= reg_wdata[IDXW-1:0];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (32'(reg_addr))
      0: reg_rdata = {30'b0, gstat};
      1: reg_rdata = {30'b0, ien};
      2: reg_rdata = {16'b0, summ};
      3: reg_rdata = 32'(ovf);
      default: ;
    endcase
    for (int i = 0; i < NQ; i++)
      if (32'(reg_addr) == i + 4)
        reg_rdata = (32'(widx[i]) << 16) | 32'(ridx[i]);
  end

  assign irq = |(gstat & ien);
endmodule

// File: rtl/stq_poster_chk.sv
module stq_poster_chk (
  input logic clk,
  input logic rst_n,
  input logic take,
  input logic drop,
  input logic mem_we,
  input logic mem_flag,
  input logic posted
);
  AST_ENTRY_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> mem_flag); // R1
  AST_WRITE_FOLLOWS_TAKE: assert property (@(posedge clk) disable iff (!rst_n) take |=> mem_we); // R1
  AST_DROP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) drop |=> !mem_we); // R3
  AST_POSTED_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n) $rose(posted) |-> $past(mem_we)); // R5
endmodule

bind stq_poster stq_poster_chk chk_i (
  .clk(clk), .rst_n(rst_n), .take(take), .drop(drop),
  .mem_we(mem_we), .mem_flag(mem_wdata[EW-1]), .posted(gstat[0])
);

// File: tb/stq_poster_tb_top.sv
`timescale 1ns/1ps
module stq_poster_tb_top;
  localparam int NQ = 20, IDXW = 3, EW = 32;
  localparam int QW = $clog2(NQ), RAW = $clog2(NQ+4), D = 1 << IDXW;

  logic clk = 0, rst_n = 0;
  logic post_valid = 0, post_ready;
  logic [QW-1:0] post_queue = '0;
  logic [EW-2:0] post_info = '0;
  logic mem_we;
  logic [QW+IDXW-1:0] mem_addr;
  logic [EW-1:0] mem_wdata;
  logic reg_we = 0;
  logic [RAW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq;

  always #4 clk = ~clk;

  stq_poster #(.NQ(NQ), .IDXW(IDXW), .EW(EW)) dut_i (.*);

  int n_chk = 0, n_fail = 0;
  int m_w [NQ], m_r [NQ];
  int m_g = 0, m_ien = 0, m_s = 0, m_ovf = 0;

  function automatic bit exp_full(int q);
    return ((m_w[q] + 1) % D) == m_r[q];
  endfunction

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(int a, output logic [31:0] v);
    reg_addr = a[RAW-1:0];
    #1 v = reg_rdata;
  endtask

  task automatic check_all(int q);
    logic [31:0] v;
    rd(0, v); chk("R7 gstat", v, m_g);
    rd(1, v); chk("R8 enable", v, m_ien);
    rd(2, v); chk("R6 summary", v, m_s);
    rd(3, v); chk("R3 overflow", v, m_ovf);
    if (q >= 0 && q < NQ) begin
      rd(4 + q, v); chk("R2 R4 index reg", v, (m_w[q] << 16) | m_r[q]);
    end
    chk("R8 irq", irq, (m_g & m_ien) != 0);
  endtask

  task automatic reg_write(int a, int d);
    @(negedge clk);
    reg_we = 1; reg_addr = a[RAW-1:0]; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 0;
    case (a)
      0: m_g   &= ~(d & 3);
      1: m_ien  = d & 3;
      2: m_s   &= ~(d & 16'hFFFF);
      3: m_ovf &= ~(d & ((1 << NQ) - 1));
      default: if (a >= 4 && a < 4 + NQ) m_r[a-4] = d % D;
    endcase
  endtask

  task automatic do_post(int q, logic [EW-2:0] info, bit collide);
    bit inr, fl;
    @(negedge clk);
    chk("R9 ready idle", post_ready, 1);
    post_valid = 1; post_queue = q[QW-1:0]; post_info = info;
    inr = q < NQ;
    fl  = inr && exp_full(q);
    @(posedge clk);
    @(negedge clk);
    post_valid = 0;
    if (inr && !fl) begin
      chk("R1 mem_we", mem_we, 1);
      chk("R1 addr", mem_addr, q * D + m_w[q]);
      chk("R1 data", mem_wdata, {1'b1, info});
      chk("R9 ready low", post_ready, 0);
      chk("R5 not early", reg_rdata_g0(), m_g & 1);
      if (collide) begin
        reg_we = 1; reg_addr = '0; reg_wdata = 1;
      end
      @(posedge clk);
      @(negedge clk);
      reg_we = 0;
      chk("R1 single write", mem_we, 0);
      m_w[q] = (m_w[q] + 1) % D;
      if (collide) m_g &= ~1;
      m_g |= 1;
      if (q < 16) m_s |= 1 << q;
    end else begin
      chk(inr ? "R3 drop no write" : "R10 ignored", mem_we, 0);
      if (fl) begin
        m_ovf |= 1 << q;
        m_g |= 2;
      end
    end
    check_all(q);
  endtask

  function automatic int reg_rdata_g0();
    return (reg_addr == 0) ? reg_rdata & 1 : m_g & 1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4242));
    for (int i = 0; i < NQ; i++) begin m_w[i] = 0; m_r[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk("R9 reset ready", post_ready, 1);
    chk("R9 reset irq", irq, 0);
    chk("R9 reset mem_we", mem_we, 0);
    check_all(0);

    // R5 / R8: enable both, fill queue 0 to full, then overflow (R3)
    reg_write(1, 3); check_all(0);
    for (int k = 0; k < D - 1; k++) do_post(0, EW'(k + 100), 0);
    do_post(0, 31'h55, 0);
    chk("R3 write index held", m_w[0], D - 1);
    // R4: host returns read index; posting wraps (R2)
    reg_write(4, 5); check_all(0);
    for (int k = 0; k < 5; k++) do_post(0, EW'(k + 200), 0);
    do_post(0, 31'h66, 0);
    // R6: high queue sets status but no summary
    reg_write(0, 3); reg_write(2, 16'hFFFF); check_all(0);
    do_post(17, 31'h1717, 0);
    do_post(15, 31'h1515, 0);
    // R10: out of range queue
    reg_write(0, 3); check_all(-1);
    do_post(NQ + 3, 31'h7, 0);
    do_post(31, 31'h9, 0);
    // R7: clear collides with set
    do_post(3, 31'h33, 1);
    reg_write(3, 1); check_all(0);
    // R8 enable masks
    reg_write(1, 2); check_all(3);
    reg_write(1, 0); check_all(3);

    for (int it = 0; it < 400; it++) begin
      int sel = $urandom_range(0, 9);
      int q = $urandom_range(0, NQ - 1);
      if (sel < 6) do_post(q, EW'($urandom), $urandom_range(0, 7) == 0);
      else if (sel < 8) begin
        reg_write(4 + q, $urandom_range(0, 3) == 0 ? $urandom_range(0, D - 1) : m_w[q]);
        check_all(q);
      end else if (sel == 8) begin
        reg_write($urandom_range(0, 3), $urandom);
        check_all(q);
      end else begin
        reg_write(1, $urandom_range(0, 3));
        check_all(q);
      end
    end
    rd(0, v);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule